// File: doc/BRIEF.md
# Four-Channel Monitor Register Bank with I2C Slave

This block is the host-facing side of a four-channel voltage monitor. An external I2C master reaches sixteen byte registers through an 8-bit pointer. The pointer picks one of four channels and one of four registers in that channel: the last conversion result, a configuration byte, a lower limit and an upper limit. The SCL and SDA lines are oversampled by the system clock. Start, stop and clock edges are found in that domain, so the block needs no second clock.

A transfer starts with the device address and the R/W bit. A write then carries a pointer byte and one data byte. A read sends one data byte from the register the pointer selects. The host can set the pointer in a write phase and follow it with a repeated start, or it can skip that step and read at the pointer already held. Conversion results enter from the converter side through a strobe port. The limits and the configuration fields go out as flat vectors to the comparators and the sequencer. Each read data byte also raises a one-cycle strobe that carries the channel number, which a comparator in latched mode uses to clear its flag.

Four configuration bits are shared by all channels: shutdown, soft reset, fast interval and interval enable. A write to any channel's configuration register sets them for every channel. Two bits are kept per channel: interrupt mode and output polarity. The soft reset bit and the active-low hold input both return the bank to its reset state.

Top module: `qmon_i2c_regbank`

## Requirements
- R1: The slave acknowledges only the 7-bit address 1001111 (0x4F). For any other address it leaves SDA released for the rest of the transfer.
- R2: The pointer byte is stored whole. Bits [3:2] give the channel (0 to 3). Bits [1:0] give the register: 00 result, 01 configuration, 10 lower limit, 11 upper limit.
- R3: In a write, the byte after the pointer is stored in the selected configuration or limit register and is acknowledged. The limits appear on lim_lo_o and lim_hi_o at bit offset 8*channel.
- R4: A read returns the selected register MSB first. The pointer may be set in a write phase followed by a repeated start, or taken as already held. The pointer resets to 0x00.
- R5: After reset, every result register reads 0xFF, every configuration register reads 0x00, every lower limit reads 0x66 and every upper limit reads 0x80.
- R6: Configuration bits 0 (shutdown), 3 (soft reset), 4 (fast interval) and 5 (interval enable) are shared, and the last write to any channel sets them. Bits 1 (interrupt mode) and 2 (active-high polarity) are kept per channel. Bits 7:6 read 0.
- R7: Only res_vld_i writes a result register, storing res_data_i into channel res_ch_i. A host write to a result register is acknowledged and has no effect.
- R8: A pointer whose bits [7:4] are not zero is reserved. Writes through it are acknowledged and ignored, and reads through it return 0x00.
- R9: While the soft reset bit is 1, every register is held at its reset value except that bit. A configuration write then changes only bit 3. conv_reset_o and power_save_o are high.
- R10: While stop_ni is low, all state returns to reset, including the pointer and the soft reset bit, and power_save_o and conv_reset_o are high.
- R11: Each read data byte raises rd_pulse_o for exactly one cycle, with rd_ch_o equal to pointer bits [3:2].
- R12: Only one data byte is handled per transfer. A second written byte is not acknowledged. After a read byte the slave releases SDA until the next start, whether the host acknowledged or not.
- R13: power_save_o follows the shutdown bit. ival_en_o and ival_fast_o follow bits 5 and 4, and int_mode_o and od_pol_o carry the per-channel bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_ni | input | 1 | Active-low hold: clears all state and forces power save |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| res_vld_i | input | 1 | Conversion result strobe |
| res_ch_i | input | 2 | Channel of the conversion result |
| res_data_i | input | 8 | Conversion result value |
| rd_pulse_o | output | 1 | One-cycle strobe per read data byte |
| rd_ch_o | output | 2 | Channel of the byte that was read |
| power_save_o | output | 1 | Shutdown bit, soft reset or hold active |
| conv_reset_o | output | 1 | Soft reset or hold active |
| ival_en_o | output | 1 | Interval conversion mode |
| ival_fast_o | output | 1 | Short interval selected |
| int_mode_o | output | 4 | Per-channel latched (interrupt) mode |
| od_pol_o | output | 4 | Per-channel active-high output polarity |
| lim_lo_o | output | 32 | Lower limits, channel c at bits [8c+7:8c] |
| lim_hi_o | output | 32 | Upper limits, channel c at bits [8c+7:8c] |

## Verification
A converter result update can land in the same clock cycle in which the bus engine latches a result register into its transmit shifter. A host limit write can also coincide with a converter strobe. The bench holds res_vld_i active for channel 3 through a whole read of that channel's result register, so one of the strobes is certain to fall on the load cycle. The byte on the bus must then equal the strobed value. A limit write made during the same run of strobes must appear on lim_hi_o next to the updated result, which shows that neither path blocks the other. The soft reset bit gets the same treatment: limit and configuration writes issued while it is set must leave the outputs and readback at reset values, and only bit 3 may change.

// File: rtl/qmon_pkg.sv
package qmon_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK, S_SKIP} bus_st_e;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} byte_kind_e;

  localparam logic [1:0] REG_RES = 2'd0;
  localparam logic [1:0] REG_CFG = 2'd1;
  localparam logic [1:0] REG_LO  = 2'd2;
  localparam logic [1:0] REG_HI  = 2'd3;

  localparam logic [7:0] RES_RST = 8'hFF;
  localparam logic [7:0] LO_RST  = 8'h66;
  localparam logic [7:0] HI_RST  = 8'h80;
endpackage

// File: rtl/qmon_i2c_sync.sv
module qmon_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d, scl_s;

  assign scl_s = scl_sr[STAGES-1];
  assign sda_o = sda_sr[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_o;
    end
  end

  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/qmon_i2c_ctrl.sv
module qmon_i2c_ctrl
  import qmon_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rdata_i,
  output logic       sda_oe_o,
  output logic [7:0] ptr_o,
  output logic       wr_o,
  output logic [7:0] wdata_o,
  output logic       rd_o
);
  bus_st_e    st_q;
  byte_kind_e kind_q;
  logic [7:0] sr_q, tx_q;
  logic [2:0] cnt_q;
  logic       pend_q, rw_q;

  assign wdata_o = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; kind_q <= K_ADDR; sr_q <= '0; tx_q <= '0; cnt_q <= '0;
      pend_q <= 1'b0; rw_q <= 1'b0; sda_oe_o <= 1'b0; ptr_o <= '0; wr_o <= 1'b0; rd_o <= 1'b0;
    end else if (clr_i) begin
      st_q <= S_IDLE; pend_q <= 1'b0; sda_oe_o <= 1'b0; ptr_o <= '0; wr_o <= 1'b0; rd_o <= 1'b0;
    end else begin
      wr_o <= 1'b0;
      rd_o <= 1'b0;
      if (start_i) begin
        st_q <= S_RX; kind_q <= K_ADDR; cnt_q <= '0; pend_q <= 1'b0; sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st_q <= S_IDLE; pend_q <= 1'b0; sda_oe_o <= 1'b0;
      end else begin
        case (st_q)
          S_RX: begin
            if (scl_rise_i) begin
              sr_q  <= {sr_q[6:0], sda_i};
              cnt_q <= cnt_q + 3'd1;
              if (cnt_q == 3'd7) pend_q <= 1'b1;
            end else if (scl_fall_i && pend_q) begin
              pend_q <= 1'b0;
              cnt_q  <= '0;
              case (kind_q)
                K_ADDR: begin
                  if (sr_q[7:1] == DEV_ADDR) begin
                    rw_q <= sr_q[0]; sda_oe_o <= 1'b1; st_q <= S_ACK;
                  end else st_q <= S_SKIP;
                end
                K_PTR: begin
                  ptr_o <= sr_q; sda_oe_o <= 1'b1; st_q <= S_ACK;
                end
                default: begin
                  wr_o <= 1'b1; sda_oe_o <= 1'b1; st_q <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              if (kind_q == K_ADDR && rw_q) begin
                st_q <= S_TX; tx_q <= rdata_i; sda_oe_o <= ~rdata_i[7];
                rd_o <= 1'b1; cnt_q <= '0;
              end else if (kind_q == K_ADDR) begin
                st_q <= S_RX; kind_q <= K_PTR;
              end else if (kind_q == K_PTR) begin
                st_q <= S_RX; kind_q <= K_DATA;
              end else st_q <= S_SKIP;   // only one data byte per transfer
            end
          end
          S_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == 3'd7) begin
                sda_oe_o <= 1'b0; st_q <= S_TXACK;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0}; sda_oe_o <= ~tx_q[6]; cnt_q <= cnt_q + 3'd1;
              end
            end
          end
          S_TXACK: if (scl_rise_i) st_q <= S_SKIP;
          default: ;
        endcase
      end
    end
  end

  p_ack_drive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_ACK) |-> sda_oe_o);
  p_rd_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o);
  p_bus_release_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SKIP || st_q == S_IDLE) |-> !sda_oe_o);
endmodule

// File: rtl/qmon_regs.sv
module qmon_regs
  import qmon_pkg::*;
#(
  parameter int CH_BITS = 2,
  localparam int NCH = 1 << CH_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [7:0]         ptr_i,
  input  logic [7:0]         wdata_i,
  input  logic               res_vld_i,
  input  logic [CH_BITS-1:0] res_ch_i,
  input  logic [7:0]         res_data_i,
  output logic [7:0]         rdata_o,
  output logic               sd_o,
  output logic               srst_o,
  output logic               ival_en_o,
  output logic               ival_fast_o,
  output logic [NCH-1:0]     int_mode_o,
  output logic [NCH-1:0]     od_pol_o,
  output logic [NCH*8-1:0]   lim_lo_o,
  output logic [NCH*8-1:0]   lim_hi_o
);
  logic [NCH*8-1:0]   res_flat;
  logic [CH_BITS-1:0] ch;
  logic [1:0]         rsel;
  logic               ptr_ok, wr_cfg;

  assign ch     = ptr_i[2 +: CH_BITS];
  assign rsel   = ptr_i[1:0];
  assign ptr_ok = (ptr_i[7:2+CH_BITS] == '0);
  assign wr_cfg = wr_i & ptr_ok & (rsel == REG_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_o <= 1'b0; srst_o <= 1'b0; ival_en_o <= 1'b0; ival_fast_o <= 1'b0;
    end else if (clr_i) begin
      sd_o <= 1'b0; srst_o <= 1'b0; ival_en_o <= 1'b0; ival_fast_o <= 1'b0;
    end else begin
      if (srst_o) begin
        sd_o <= 1'b0; ival_en_o <= 1'b0; ival_fast_o <= 1'b0;
      end
      if (wr_cfg) begin
        srst_o <= wdata_i[3];
        if (!srst_o) begin
          sd_o <= wdata_i[0]; ival_fast_o <= wdata_i[4]; ival_en_o <= wdata_i[5];
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0] res_q, lo_q, hi_q;
    logic       mode_q, pol_q, sel;

    assign sel = wr_i & ptr_ok & (ch == CH_BITS'(c)) & ~srst_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q <= RES_RST; lo_q <= LO_RST; hi_q <= HI_RST; mode_q <= 1'b0; pol_q <= 1'b0;
      end else if (clr_i || srst_o) begin
        res_q <= RES_RST; lo_q <= LO_RST; hi_q <= HI_RST; mode_q <= 1'b0; pol_q <= 1'b0;
      end else begin
        if (res_vld_i && res_ch_i == CH_BITS'(c)) res_q <= res_data_i;
        if (sel) begin
          case (rsel)
            REG_CFG: {pol_q, mode_q} <= wdata_i[2:1];
            REG_LO:  lo_q <= wdata_i;
            REG_HI:  hi_q <= wdata_i;
            default: ;  // result register is not host-writable
          endcase
        end
      end
    end

    assign res_flat[c*8 +: 8] = res_q;
    assign lim_lo_o[c*8 +: 8] = lo_q;
    assign lim_hi_o[c*8 +: 8] = hi_q;
    assign int_mode_o[c]      = mode_q;
    assign od_pol_o[c]        = pol_q;
  end

  always_comb begin
    rdata_o = 8'h00;
    if (ptr_ok) begin
      case (rsel)
        REG_RES: rdata_o = res_flat[ch*8 +: 8];
        REG_CFG: rdata_o = {2'b00, ival_en_o, ival_fast_o, srst_o, od_pol_o[ch], int_mode_o[ch], sd_o};
        REG_LO:  rdata_o = lim_lo_o[ch*8 +: 8];
        default: rdata_o = lim_hi_o[ch*8 +: 8];
      endcase
    end
  end

  p_res_host_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rsel == REG_RES && !res_vld_i && !srst_o && !clr_i) |=> $stable(res_flat));
  p_shared_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !srst_o && !clr_i) |=> (ival_en_o == $past(wdata_i[5]) && sd_o == $past(wdata_i[0])));
  p_hold_defaults_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (lim_lo_o[7:0] == LO_RST && lim_hi_o[7:0] == HI_RST && !int_mode_o[0]));
endmodule

// File: rtl/qmon_i2c_regbank.sv
module qmon_i2c_regbank #(
  parameter logic [6:0] DEV_ADDR    = 7'h4F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stop_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic        res_vld_i,
  input  logic [1:0]  res_ch_i,
  input  logic [7:0]  res_data_i,
  output logic        rd_pulse_o,
  output logic [1:0]  rd_ch_o,
  output logic        power_save_o,
  output logic        conv_reset_o,
  output logic        ival_en_o,
  output logic        ival_fast_o,
  output logic [3:0]  int_mode_o,
  output logic [3:0]  od_pol_o,
  output logic [31:0] lim_lo_o,
  output logic [31:0] lim_hi_o
);
  localparam int CH_BITS = 2;

  logic       sda_s, scl_rise, scl_fall, start, stop, clr;
  logic       wr, sd, srst;
  logic [7:0] ptr, wdata, rdata;

  assign clr = ~stop_ni;

  qmon_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i, .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  qmon_i2c_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk_i, .rst_ni, .clr_i(clr), .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .rdata_i(rdata), .sda_oe_o, .ptr_o(ptr),
    .wr_o(wr), .wdata_o(wdata), .rd_o(rd_pulse_o)
  );

  qmon_regs #(.CH_BITS(CH_BITS)) u_regs (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr), .ptr_i(ptr), .wdata_i(wdata),
    .res_vld_i, .res_ch_i, .res_data_i, .rdata_o(rdata), .sd_o(sd), .srst_o(srst),
    .ival_en_o, .ival_fast_o, .int_mode_o, .od_pol_o, .lim_lo_o, .lim_hi_o
  );

  assign rd_ch_o      = ptr[3:2];
  assign conv_reset_o = clr | srst;
  assign power_save_o = clr | srst | sd;

  p_hold_power_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr) |-> (lim_lo_o == {4{8'h66}} && !sda_oe_o && !rd_pulse_o));
endmodule

// File: tb/sim_qmon_i2c_regbank.sv
module sim_qmon_i2c_regbank;
  localparam int Q = 6;
  localparam logic [6:0] ADR = 7'h4F;

  logic clk = 1'b0, rst_ni = 1'b0, stop_ni = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic res_vld = 1'b0;
  logic [1:0] res_ch = '0;
  logic [7:0] res_data = '0;
  logic sda_oe, rd_pulse, power_save, conv_reset, ival_en, ival_fast;
  logic [1:0] rd_ch;
  logic [3:0] int_mode, od_pol;
  logic [31:0] lim_lo, lim_hi;
  logic sda_line;
  int n_chk = 0, n_fail = 0, pulses = 0;
  logic [1:0] last_ch = '0;

  assign sda_line = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  qmon_i2c_regbank u0 (
    .clk_i(clk), .rst_ni, .stop_ni, .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .res_vld_i(res_vld), .res_ch_i(res_ch), .res_data_i(res_data), .rd_pulse_o(rd_pulse),
    .rd_ch_o(rd_ch), .power_save_o(power_save), .conv_reset_o(conv_reset),
    .ival_en_o(ival_en), .ival_fast_o(ival_fast), .int_mode_o(int_mode), .od_pol_o(od_pol),
    .lim_lo_o(lim_lo), .lim_hi_o(lim_hi)
  );

  always @(posedge clk) if (rd_pulse) begin pulses++; last_ch <= rd_ch; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic i2c_start; sda_m = 1'b1; wq; scl = 1'b1; wq; sda_m = 1'b0; wq; scl = 1'b0; wq; endtask
  task automatic i2c_stop; sda_m = 1'b0; wq; scl = 1'b1; wq; sda_m = 1'b1; wq; endtask
  task automatic xbit(input logic b, output logic r);
    sda_m = b; wq; scl = 1'b1; wq; r = sda_line; wq; scl = 1'b0; wq;
  endtask
  task automatic tx_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(d[i], r);
    xbit(1'b1, r);
    ack = ~r;
  endtask
  task automatic rx_byte(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin xbit(1'b1, r); d[i] = r; end
    xbit(nack, r);
  endtask
  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d, output logic ad);
    logic a0, a1;
    i2c_start; tx_byte({ADR, 1'b0}, a0); tx_byte(p, a1); tx_byte(d, ad); i2c_stop;
  endtask
  task automatic rd_reg(input logic [7:0] p, output logic [7:0] d);
    logic a;
    i2c_start; tx_byte({ADR, 1'b0}, a); tx_byte(p, a);
    i2c_start; tx_byte({ADR, 1'b1}, a); rx_byte(1'b1, d); i2c_stop;
  endtask
  task automatic rd_cur(output logic [7:0] d);
    logic a;
    i2c_start; tx_byte({ADR, 1'b1}, a); rx_byte(1'b1, d); i2c_stop;
  endtask

  function automatic logic [7:0] dflt(input logic [1:0] r);
    case (r)
      2'd0: return 8'hFF;
      2'd1: return 8'h00;
      2'd2: return 8'h66;
      default: return 8'h80;
    endcase
  endfunction
  function automatic logic [7:0] limv(input int c, input int r);
    return 8'(8'h21 + 16 * c + (r == 3 ? 8 : 0));
  endfunction

  task automatic run_tests;
    logic [7:0] d;
    logic a;
    int p0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 reset lo", lim_lo, {4{8'h66}});
    chk("R5 reset hi", lim_hi, {4{8'h80}});
    chk("R13 reset power_save", {31'd0, power_save}, 0);
    rd_cur(d);
    chk("R4 default pointer read", {24'd0, d}, 8'hFF);
    for (int p = 0; p < 16; p++) begin
      p0 = pulses;
      rd_reg(8'(p), d);
      chk("R2 R5 default sweep", {24'd0, d}, {24'd0, dflt(2'(p))});
      chk("R11 pulse count", pulses - p0, 1);
      chk("R11 pulse channel", {30'd0, last_ch}, p / 4);
    end
    i2c_start; tx_byte({7'h4E, 1'b0}, a);
    chk("R1 foreign address nack", {31'd0, a}, 0);
    tx_byte(8'h00, a);
    chk("R1 stays released", {31'd0, a}, 0);
    i2c_stop;
    i2c_start; tx_byte({ADR, 1'b0}, a); i2c_stop;
    chk("R1 own address ack", {31'd0, a}, 1);
    for (int c = 0; c < 4; c++)
      for (int r = 2; r < 4; r++) begin
        wr_reg(8'(c * 4 + r), limv(c, r), a);
        chk("R3 data ack", {31'd0, a}, 1);
      end
    for (int c = 0; c < 4; c++) begin
      chk("R3 lo out", {24'd0, lim_lo[c*8 +: 8]}, {24'd0, limv(c, 2)});
      chk("R3 hi out", {24'd0, lim_hi[c*8 +: 8]}, {24'd0, limv(c, 3)});
      rd_reg(8'(c * 4 + 3), d);
      chk("R3 hi readback", {24'd0, d}, {24'd0, limv(c, 3)});
    end
    wr_reg(8'h04, 8'h12, a);
    chk("R7 result write acked", {31'd0, a}, 1);
    rd_reg(8'h04, d);
    chk("R7 result write ignored", {24'd0, d}, 8'hFF);
    res_ch = 2'd2; res_data = 8'h5A; res_vld = 1'b1; @(negedge clk); res_vld = 1'b0;
    rd_reg(8'h08, d);
    chk("R7 converter update", {24'd0, d}, 8'h5A);
    wr_reg(8'h01, 8'h06, a);
    wr_reg(8'h05, 8'h02, a);
    rd_reg(8'h01, d); chk("R6 ch0 cfg", {24'd0, d}, 8'h06);
    rd_reg(8'h05, d); chk("R6 ch1 cfg", {24'd0, d}, 8'h02);
    rd_reg(8'h0D, d); chk("R6 ch3 cfg untouched", {24'd0, d}, 8'h00);
    chk("R13 int_mode", {28'd0, int_mode}, 4'b0011);
    chk("R13 od_pol", {28'd0, od_pol}, 4'b0001);
    wr_reg(8'h09, 8'hF1, a);
    rd_reg(8'h01, d); chk("R6 shared seen on ch0", {24'd0, d}, 8'h37);
    rd_reg(8'h0D, d); chk("R6 shared seen on ch3", {24'd0, d}, 8'h31);
    chk("R13 shared outputs", {29'd0, power_save, ival_en, ival_fast}, 3'b111);
    wr_reg(8'h0D, 8'h00, a);
    rd_reg(8'h01, d); chk("R6 shared cleared", {24'd0, d}, 8'h06);
    chk("R13 power_save off", {31'd0, power_save}, 0);
    wr_reg(8'h52, 8'h99, a);
    chk("R8 reserved write acked", {31'd0, a}, 1);
    chk("R8 reserved write ignored", {24'd0, lim_lo[7:0]}, {24'd0, limv(0, 2)});
    rd_reg(8'h52, d);
    chk("R8 reserved read zero", {24'd0, d}, 8'h00);
    i2c_start; tx_byte({ADR, 1'b0}, a); tx_byte(8'h02, a); tx_byte(8'h44, a);
    chk("R12 first data acked", {31'd0, a}, 1);
    tx_byte(8'h55, a);
    chk("R12 second data nacked", {31'd0, a}, 0);
    i2c_stop;
    chk("R12 one byte stored", {24'd0, lim_lo[7:0]}, 8'h44);
    p0 = pulses;
    i2c_start; tx_byte({ADR, 1'b1}, a); rx_byte(1'b0, d);
    chk("R4 current pointer read", {24'd0, d}, 8'h44);
    rx_byte(1'b1, d);
    chk("R12 released after read", {24'd0, d}, 8'hFF);
    i2c_stop;
    chk("R11 one pulse per transfer", pulses - p0, 1);
    // concurrency: converter strobing every cycle during a read and a limit write
    res_ch = 2'd3; res_data = 8'hC3; res_vld = 1'b1;
    rd_reg(8'h0C, d);
    chk("R7 result vs read same cycle", {24'd0, d}, 8'hC3);
    wr_reg(8'h0F, 8'hE7, a);
    res_vld = 1'b0;
    chk("R3 limit write during strobes", {24'd0, lim_hi[31:24]}, 8'hE7);
    wr_reg(8'h05, 8'h08, a);
    chk("R9 soft reset outputs", {30'd0, conv_reset, power_save}, 2'b11);
    chk("R9 limits held lo", lim_lo, {4{8'h66}});
    chk("R9 limits held hi", lim_hi, {4{8'h80}});
    wr_reg(8'h02, 8'h11, a);
    chk("R9 write ignored in hold", {24'd0, lim_lo[7:0]}, 8'h66);
    wr_reg(8'h01, 8'h3E, a);
    rd_reg(8'h09, d); chk("R9 only bit3 writable", {24'd0, d}, 8'h08);
    rd_reg(8'h0C, d); chk("R9 result held", {24'd0, d}, 8'hFF);
    wr_reg(8'h01, 8'h06, a);
    rd_reg(8'h01, d); chk("R9 release ignores other bits", {24'd0, d}, 8'h00);
    chk("R9 conv_reset off", {31'd0, conv_reset}, 0);
    wr_reg(8'h0A, 8'h77, a);
    wr_reg(8'h01, 8'h01, a);
    rd_reg(8'h0B, d);
    stop_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 hold outputs", {30'd0, conv_reset, power_save}, 2'b11);
    stop_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 lo reset", lim_lo, {4{8'h66}});
    chk("R10 shutdown cleared", {31'd0, power_save}, 0);
    rd_cur(d);
    chk("R10 pointer reset", {24'd0, d}, 8'hFF);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule